// File: doc/BRIEF.md
# Two-way virtually indexed, physically tagged cache lookup

This block is the lookup path of a set-associative cache that starts reading its tag and data arrays before the address has been translated. A request carries a virtual address. In the same cycle, a small fully associative translation buffer matches the virtual page number, and every cache way reads the set that the untranslated page-offset bits select. One cycle later, the physical page number from the translation buffer is compared with the physical tag that each way returned. That comparison decides whether the access hit and which way supplies the word.

The set index and the line offset together fit inside the page offset. Because of this, indexing needs no translation, and two virtual pages that map to one physical page land on the same cache line. A failed translation is reported to the requester, and the surrounding logic loads the missing mapping through a fill port and retries. A translated access that finds no matching tag raises a request for the physical line. The line comes back on a separate fill port and is installed into the least recently used way of its set.

Top module: `vipt_cache`

## Requirements
- R1: After synchronous reset, no translation entry and no cache line is valid, and rsp_valid, rsp_hit, rsp_tlb_miss and fill_req_valid are all low.
- R2: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high, and low otherwise.
- R3: When the virtual page number matches no valid translation entry, the response has rsp_tlb_miss high, rsp_hit low and fill_req_valid low, even if a line with a matching physical tag is stored in the selected set.
- R4: Translation fills write entries 0 to 7 in order and wrap back to entry 0, so the ninth fill replaces the mapping written by the first fill.
- R5: With a valid translation and a valid way whose tag equals the physical page number, rsp_hit is high. rsp_data is 32-bit word va[3:2] of that line, where word 0 occupies line bits 31:0. Requests are word aligned.
- R6: With a valid translation and no matching way, fill_req_valid is high in the response cycle, and fill_req_addr is {ppn, va[11:4], 4'b0000}.
- R7: A line fill at line_fill_addr writes set line_fill_addr[9:4] with tag line_fill_addr[31:12]. It goes into way 0 if that way is invalid, otherwise into way 1 if that way is invalid, otherwise into the least recently used way.
- R8: After a hit in way w or a fill into way w, the other way of that set becomes the least recently used way.
- R9: The set is chosen only from virtual address bits 9:4, so two virtual pages that map to the same physical page hit the same stored line.
- R10: Two lines with different physical tags coexist in the two ways of one set, and each hits independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address of the lookup |
| tlb_fill_valid | input | 1 | Write one translation entry |
| tlb_fill_vpn | input | 20 | Virtual page number to install |
| tlb_fill_ppn | input | 20 | Physical page number to install |
| line_fill_valid | input | 1 | Install one line from memory |
| line_fill_addr | input | 32 | Physical address of the returned line |
| line_fill_data | input | 128 | Returned line contents |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translated access found its line |
| rsp_tlb_miss | output | 1 | No translation for the virtual page |
| rsp_data | output | 32 | Selected word of the hitting line |
| fill_req_valid | output | 1 | Line fetch request on a cache miss |
| fill_req_addr | output | 32 | Line-aligned physical address to fetch |

## Verification
The hardest case to reach from the ports is a stale line whose physical tag still matches while its translation is gone. Reaching it takes a line cached through one mapping, then enough further translation fills to wrap the round-robin pointer past that entry, and then a request to the old virtual page. The stimulus does exactly that, after first driving both ways of one set through a hit that reorders the replacement choice and a fill that evicts the older line. A behavioural model in the bench predicts the response of every access, including the evicted and the aliased cases.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int LINE_OFF_W = 4;
    localparam int SET_CNT    = 64;
    localparam int WAY_CNT    = 2;
    localparam int TLB_CNT    = 8;
    localparam int WORD_W     = 32;

    localparam int PN_W   = VA_W - PAGE_OFF_W;
    localparam int IDX_W  = $clog2(SET_CNT);
    localparam int LINE_W = 8 * (1 << LINE_OFF_W);

    typedef logic [PN_W-1:0]   pn_t;
    typedef logic [LINE_W-1:0] line_t;

    // Result of one translation lookup, held for the compare stage
    typedef struct packed {
        logic hit;
        pn_t  ppn;
    } xlat_t;

    function automatic logic [WORD_W-1:0] pick_word(line_t line, logic [LINE_OFF_W-3:0] sel);
        return line[sel*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int PN_W    = 20,
    parameter int ENTRIES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PN_W-1:0] lk_vpn,
    input  logic            fill_valid,
    input  logic [PN_W-1:0] fill_vpn,
    input  logic [PN_W-1:0] fill_ppn,
    output logic            res_hit,
    output logic [PN_W-1:0] res_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] ent_v;
    logic [PN_W-1:0]    ent_vpn [ENTRIES];
    logic [PN_W-1:0]    ent_ppn [ENTRIES];
    logic [PTR_W-1:0]   ptr;
    logic               any_match;
    logic [PN_W-1:0]    sel_ppn;

    // Lowest matching entry wins
    always_comb begin
        any_match = 1'b0;
        sel_ppn   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_v[i] && ent_vpn[i] == lk_vpn) begin
                any_match = 1'b1;
                sel_ppn   = ent_ppn[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v   <= '0;
            ptr     <= '0;
            res_hit <= 1'b0;
            res_ppn <= '0;
        end else begin
            if (fill_valid) begin
                ent_v[ptr] <= 1'b1;
                ptr        <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
            end
            if (lk_valid) begin
                res_hit <= any_match;
                res_ppn <= sel_ppn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            ent_vpn[ptr] <= fill_vpn;
            ent_ppn[ptr] <= fill_ppn;
        end
    end

    AST_TLB_ROUND_ROBIN: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)); // R4

endmodule

// File: rtl/vipt_way.sv
module vipt_way #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              wr_set_valid
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    assign wr_set_valid = valid_q[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en)
                valid_q[wr_idx] <= 1'b1;
            if (rd_en)
                rd_valid <= valid_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
        if (rd_en) begin
            rd_tag  <= tag_mem[rd_idx];
            rd_line <= line_mem[rd_idx];
        end
    end

    AST_WAY_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]); // R7

endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             victim
);
    localparam int SETS = 1 << IDX_W;

    // One bit per set naming the way to replace next
    logic [SETS-1:0] old_q;

    assign victim = old_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst)
            old_q <= '0;
        else if (upd_en)
            old_q[upd_idx] <= ~upd_way;
    end

    AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> old_q[$past(upd_idx)] != $past(upd_way)); // R8

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int VA_W_P       = VA_W,
    parameter int PAGE_OFF_W_P = PAGE_OFF_W,
    parameter int LINE_OFF_W_P = LINE_OFF_W,
    parameter int SET_CNT_P    = SET_CNT,
    parameter int WAY_CNT_P    = WAY_CNT,
    parameter int TLB_CNT_P    = TLB_CNT,
    parameter int WORD_W_P     = WORD_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    input  logic [VA_W_P-1:0]                  req_va,
    input  logic                               tlb_fill_valid,
    input  logic [VA_W_P-PAGE_OFF_W_P-1:0]     tlb_fill_vpn,
    input  logic [VA_W_P-PAGE_OFF_W_P-1:0]     tlb_fill_ppn,
    input  logic                               line_fill_valid,
    input  logic [VA_W_P-1:0]                  line_fill_addr,
    input  logic [8*(1<<LINE_OFF_W_P)-1:0]     line_fill_data,
    output logic                               rsp_valid,
    output logic                               rsp_hit,
    output logic                               rsp_tlb_miss,
    output logic [WORD_W_P-1:0]                rsp_data,
    output logic                               fill_req_valid,
    output logic [VA_W_P-1:0]                  fill_req_addr
);
    localparam int PNW   = VA_W_P - PAGE_OFF_W_P;
    localparam int IW    = $clog2(SET_CNT_P);
    localparam int LW    = 8 * (1 << LINE_OFF_W_P);
    localparam int SEL_W = LINE_OFF_W_P - 2;
    localparam int OFF_W = PAGE_OFF_W_P - LINE_OFF_W_P;

    // Indexing must stay inside the page offset; the replacement logic is two-way
    if (IW + LINE_OFF_W_P > PAGE_OFF_W_P) begin : g_bad_index
        $error("set index reaches into the virtual page number");
    end
    if (WAY_CNT_P != 2) begin : g_bad_ways
        $error("one-bit replacement supports exactly two ways");
    end

    // Compare stage registers
    logic             rsp_v_q;
    logic [OFF_W-1:0] line_off_q;
    logic [SEL_W-1:0] wsel_q;
    xlat_t            xl;

    logic [IW-1:0] req_idx, fill_idx, rsp_idx;
    assign req_idx  = req_va[LINE_OFF_W_P +: IW];
    assign fill_idx = line_fill_addr[LINE_OFF_W_P +: IW];
    assign rsp_idx  = line_off_q[IW-1:0];

    vipt_tlb #(.PN_W(PNW), .ENTRIES(TLB_CNT_P)) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (req_valid),
        .lk_vpn     (req_va[VA_W_P-1:PAGE_OFF_W_P]),
        .fill_valid (tlb_fill_valid),
        .fill_vpn   (tlb_fill_vpn),
        .fill_ppn   (tlb_fill_ppn),
        .res_hit    (xl.hit),
        .res_ppn    (xl.ppn)
    );

    logic [WAY_CNT_P-1:0] rd_valid, way_hit, set_valid, way_we;
    logic [PNW-1:0]       rd_tag  [WAY_CNT_P];
    logic [LW-1:0]        rd_line [WAY_CNT_P];
    logic                 lru_victim, fill_way;

    for (genvar w = 0; w < WAY_CNT_P; w++) begin : g_way
        vipt_way #(.IDX_W(IW), .TAG_W(PNW), .LINE_W(LW)) u_way (
            .clk          (clk),
            .rst          (rst),
            .rd_en        (req_valid),
            .rd_idx       (req_idx),
            .rd_valid     (rd_valid[w]),
            .rd_tag       (rd_tag[w]),
            .rd_line      (rd_line[w]),
            .wr_en        (way_we[w]),
            .wr_idx       (fill_idx),
            .wr_tag       (line_fill_addr[VA_W_P-1:PAGE_OFF_W_P]),
            .wr_line      (line_fill_data),
            .wr_set_valid (set_valid[w])
        );
        assign way_hit[w] = rsp_v_q && xl.hit && rd_valid[w] && (rd_tag[w] == xl.ppn);
        assign way_we[w]  = line_fill_valid && (fill_way == 1'(w));
    end

    // Invalid ways are filled first, lowest number first
    assign fill_way = !set_valid[0] ? 1'b0 : (!set_valid[1] ? 1'b1 : lru_victim);

    logic          upd_en, upd_way;
    logic [IW-1:0] upd_idx;
    always_comb begin
        upd_en  = line_fill_valid || rsp_hit;
        upd_idx = line_fill_valid ? fill_idx : rsp_idx;
        upd_way = line_fill_valid ? fill_way : way_hit[1];
    end

    vipt_lru #(.IDX_W(IW)) u_lru (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (upd_en),
        .upd_idx (upd_idx),
        .upd_way (upd_way),
        .rd_idx  (fill_idx),
        .victim  (lru_victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_v_q    <= 1'b0;
            line_off_q <= '0;
            wsel_q     <= '0;
        end else begin
            rsp_v_q <= req_valid;
            if (req_valid) begin
                line_off_q <= req_va[PAGE_OFF_W_P-1:LINE_OFF_W_P];
                wsel_q     <= req_va[LINE_OFF_W_P-1:2];
            end
        end
    end

    logic [LW-1:0] hit_line;
    always_comb begin
        hit_line = '0;
        for (int w = 0; w < WAY_CNT_P; w++)
            if (way_hit[w])
                hit_line = rd_line[w];
    end

    assign rsp_valid      = rsp_v_q;
    assign rsp_hit        = |way_hit;
    assign rsp_tlb_miss   = rsp_v_q && !xl.hit;
    assign rsp_data       = hit_line[wsel_q*WORD_W_P +: WORD_W_P];
    assign fill_req_valid = rsp_v_q && xl.hit && !(|way_hit);
    assign fill_req_addr  = {xl.ppn, line_off_q, {LINE_OFF_W_P{1'b0}}};

    AST_TLB_MISS_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_tlb_miss |-> !rsp_hit && !fill_req_valid); // R3
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(way_hit)); // R10
    AST_FILL_REQ_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        fill_req_valid |-> rsp_valid && !rsp_hit); // R6
    AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_va[1:0] == 2'b00); // R5
    AST_FILL_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        line_fill_valid |-> line_fill_addr[LINE_OFF_W_P-1:0] == '0); // R7

endmodule

// File: tb/vipt_cache_test.sv
module vipt_cache_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [31:0]  req_va = '0;
    logic         tlb_fill_valid = 1'b0;
    logic [19:0]  tlb_fill_vpn = '0;
    logic [19:0]  tlb_fill_ppn = '0;
    logic         line_fill_valid = 1'b0;
    logic [31:0]  line_fill_addr = '0;
    logic [127:0] line_fill_data = '0;
    logic         rsp_valid, rsp_hit, rsp_tlb_miss, fill_req_valid;
    logic [31:0]  rsp_data, fill_req_addr;

    always #5 clk = ~clk;

    vipt_cache uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_va(req_va),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
        .line_fill_valid(line_fill_valid), .line_fill_addr(line_fill_addr), .line_fill_data(line_fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss), .rsp_data(rsp_data),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr)
    );

    int total = 0;
    int bad   = 0;

    // Behavioural reference state
    bit        m_tv   [8];
    bit [19:0] m_tvpn [8];
    bit [19:0] m_tppn [8];
    int        m_ptr = 0;
    bit        m_cv   [64][2];
    bit [19:0] m_ctag [64][2];
    int        m_old  [64];
    bit [31:0] last_fill_addr;
    bit        last_needs_fill;

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [127:0] line_of(logic [31:0] pa);
        logic [127:0] l;
        for (int k = 0; k < 4; k++)
            l[k*32 +: 32] = pa ^ 32'h5A00_0000 ^ (k * 32'h0101_0101);
        return l;
    endfunction

    // Response strobe compared on every clock
    logic exp_rv = 1'b0;
    always @(posedge clk) exp_rv <= rst ? 1'b0 : req_valid;
    always @(negedge clk)
        if (!rst) check("R2 rsp_valid", {31'b0, rsp_valid}, {31'b0, exp_rv});

    task automatic tlb_fill(logic [19:0] vpn, logic [19:0] ppn);
        @(negedge clk);
        tlb_fill_valid = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
        @(negedge clk);
        tlb_fill_valid = 1'b0;
        m_tv[m_ptr] = 1'b1; m_tvpn[m_ptr] = vpn; m_tppn[m_ptr] = ppn;
        m_ptr = (m_ptr + 1) % 8;
    endtask

    task automatic line_fill(logic [31:0] pa);
        int s, w;
        @(negedge clk);
        line_fill_valid = 1'b1; line_fill_addr = pa; line_fill_data = line_of(pa);
        @(negedge clk);
        line_fill_valid = 1'b0;
        s = int'(pa[9:4]);
        w = !m_cv[s][0] ? 0 : (!m_cv[s][1] ? 1 : m_old[s]);
        m_cv[s][w] = 1'b1; m_ctag[s][w] = pa[31:12];
        m_old[s] = 1 - w;
    endtask

    task automatic access(logic [31:0] va, string rq);
        bit t_hit, c_hit;
        bit [19:0] ppn;
        int s, hw;
        bit [31:0] pa_line;
        t_hit = 0; ppn = '0; c_hit = 0; hw = 0;
        for (int i = 7; i >= 0; i--)
            if (m_tv[i] && m_tvpn[i] == va[31:12]) begin t_hit = 1; ppn = m_tppn[i]; end
        s = int'(va[9:4]);
        if (t_hit)
            for (int w = 0; w < 2; w++)
                if (m_cv[s][w] && m_ctag[s][w] == ppn) begin c_hit = 1; hw = w; end
        pa_line = {ppn, va[11:4], 4'b0};
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        check({rq, " tlb_miss"}, {31'b0, rsp_tlb_miss}, {31'b0, !t_hit});
        check({rq, " hit"}, {31'b0, rsp_hit}, {31'b0, c_hit});
        check({rq, " fill_req"}, {31'b0, fill_req_valid}, {31'b0, t_hit && !c_hit});
        if (t_hit && !c_hit) check({rq, " R6 fill_addr"}, fill_req_addr, pa_line);
        if (c_hit) begin
            logic [127:0] l;
            l = line_of(pa_line);
            check({rq, " R5 data"}, rsp_data, l[va[3:2]*32 +: 32]);
            m_old[s] = 1 - hw;
        end
        last_needs_fill = t_hit && !c_hit;
        last_fill_addr  = pa_line;
    endtask

    task automatic access_fill(logic [31:0] va, string rq);
        access(va, rq);
        if (last_needs_fill) line_fill(last_fill_addr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs after reset
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 rsp_hit", {31'b0, rsp_hit}, 32'd0);
        check("R1 rsp_tlb_miss", {31'b0, rsp_tlb_miss}, 32'd0);
        check("R1 fill_req", {31'b0, fill_req_valid}, 32'd0);
        access(32'h0000_1234, "R1 R3 empty tlb");

        tlb_fill(20'h00010, 20'h00300);
        access_fill(32'h0001_0040, "R6 first miss");
        access(32'h0001_0040, "R5 hit word0");
        access(32'h0001_004C, "R5 hit word3");
        tlb_fill(20'h00022, 20'h00300);
        access(32'h0002_2048, "R9 alias");

        tlb_fill(20'h00031, 20'h00400);
        access_fill(32'h0003_1040, "R7 second way");
        access(32'h0003_1044, "R10 way1 hit");
        access(32'h0001_0040, "R10 way0 hit");
        tlb_fill(20'h00045, 20'h00500);
        access_fill(32'h0004_5040, "R8 evict lru");
        access(32'h0004_5048, "R8 new line");
        access(32'h0003_1040, "R8 evicted line");
        access(32'h0001_0044, "R8 kept line");
        access_fill(32'h0003_1040, "R8 refetch");
        access(32'h0003_1040, "R8 refetched");
        access(32'h0004_5040, "R8 second eviction");

        for (int i = 0; i < 4; i++) tlb_fill(20'h00050 + 20'(i), 20'h00600 + 20'(i));
        access_fill(32'h0005_2100, "R4 entry6");
        access(32'h0005_2108, "R4 entry6 hit");
        tlb_fill(20'h00060, 20'h00700);
        access(32'h0001_0040, "R3 R4 wrapped entry");
        access(32'h0002_2040, "R4 entry1 kept");
        access(32'h0006_0040, "R4 new entry0");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule